// File: doc/BRIEF.md
# Bus turnaround idle-cycle inserter

This block sits in front of an external memory bus sequencer. It keeps bus drivers from colliding when a slow device is still releasing the shared data lines. It watches each access as it is accepted and records the area of that access, its direction and whether it was a DMA transfer. When a following access could collide with the driver of the previous one, it holds off the handshake for a programmable number of clock cycles. A collision is possible when the area changes, or when a write follows a read.

The gap lengths live in a 32-bit configuration word. The word has eight 4-bit slots, and the low three bits of each slot are the idle count. Slots 0 to 6 belong to areas 0 to 6. Slot 7 is used for DMA transfers and for area 7. The power-on reset loads the word. The warm reset clears only the access history and the running gap, so a configuration set up once survives it.

The gap starts counting when an access is accepted. Any cycles in which no request is presented therefore count toward the idle time, and a request that arrives late stalls only for what remains.

Top module: `turnaround_gap_ctrl`

## Requirements
- R1: The power-on reset (`rst_n` low at a clock edge) loads the configuration word with 0x77777777, so every idle count reads 7.
- R2: `cfg_rdata` always shows the configuration word. A write (`cfg_we` high at a clock edge) stores `cfg_wdata` into bits 2:0, 6:4, 10:8, 14:12, 18:16, 22:20, 26:24 and 30:28. Bits 3, 7, 11, 15, 19, 23, 27 and 31 always read 0, whatever value is written to them.
- R3: The idle count for slot k is held in bits 4k+2 down to 4k. Accesses to areas 0 to 6 use slot 0 to 6. Slot 7 (bits 30:28) serves DMA transfers and area 7.
- R4: The warm reset (`warm_rst_n` low at a clock edge) leaves the configuration word unchanged. It clears the access history and any running gap, so the next access is accepted with no stall.
- R5: An access whose area differs from the previous accepted access stalls for the idle count of the previous access's slot.
- R6: A write that follows a read in the same area stalls for that area's idle count.
- R7: No stall is inserted for a read after a read in the same area, a write after a write in the same area, or a read after a write in the same area.
- R8: When the previous accepted access was a DMA transfer (`req_dma` high), the gap uses slot 7 instead of that access's area slot.
- R9: The gap counter is loaded when an access is accepted and falls by one on every clock. `req_ready` is low only while a collision case is presented and the counter is nonzero. An idle count of 0 therefore gives no stall, and cycles without a request shorten the stall.
- R10: A configuration write made while a gap is running does not change that gap. It applies only to gaps loaded after it.
- R11: The first access after the power-on reset is accepted with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; reloads configuration |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low; keeps configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access may issue this cycle |
| req_area | input | 3 | Area number of the presented access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Access is a DMA transfer |

## Verification
The configuration word changes at the clock edge that samples a write or a reset, so the bench reads `cfg_rdata` at the next falling edge. After an access is accepted, the counter holds the loaded count from the first falling edge onward, and `req_ready` reacts to the presented request within the same cycle. The bench therefore sets the request at a falling edge, lets the combinational path settle, and counts the falling edges at which `req_ready` is low. The expected stall is the previous access's count minus the number of falling edges since that access was accepted, with a floor of zero. It is computed from a model that captures that count at acceptance, so a configuration write made during a gap leaves the expected value alone.

// File: rtl/gap_pkg.sv
// Shared sizes and helpers for the turnaround idle-cycle inserter.
// Assumes a slot per area code, with the last slot doubling for DMA.
package gap_pkg;
    localparam int AREA_W   = 3;
    localparam int FIELD_W  = 3;
    localparam int SLOT_W   = 4;
    localparam int N_SLOTS  = 1 << AREA_W;
    localparam int CFG_W    = N_SLOTS * SLOT_W;
    localparam int DMA_SLOT = N_SLOTS - 1;

    typedef logic [AREA_W-1:0]  slot_t;
    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [CFG_W-1:0]   cfg_t;

    // Return the idle-count field of one slot.
    function automatic field_t pick_field(cfg_t c, slot_t s);
        return c[int'(s)*SLOT_W +: FIELD_W];
    endfunction
endpackage

// File: rtl/gap_cfg_reg.sv
// Configuration word: one idle-count field per slot. Spare bits are
// constant zero. Only the power-on reset initialises it (all ones per field).
module gap_cfg_reg
    import gap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cfg_t wdata,
    output cfg_t q
);
    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_slot
            field_t f_q;
            // Hold one field; load on write, max on power-on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)  f_q <= '1;
                else if (we) f_q <= wdata[g*SLOT_W +: FIELD_W];
            end
            assign q[g*SLOT_W +: FIELD_W]                = f_q;
            assign q[g*SLOT_W+FIELD_W +: SLOT_W-FIELD_W] = '0;
        end
    endgenerate
endmodule

// File: rtl/gap_history.sv
// Remembers the last accepted access and flags a possible collision
// with the presented one. Assumes area and direction are valid with the request.
module gap_history
    import gap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  warm_n,
    input  logic  accept,
    input  slot_t area,
    input  logic  wr,
    output logic  hazard
);
    logic  seen_q;
    slot_t last_area_q;
    logic  last_wr_q;

    // Capture the accepted access; both resets forget it.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_n) begin
            seen_q      <= 1'b0;
            last_area_q <= '0;
            last_wr_q   <= 1'b0;
        end else if (accept) begin
            seen_q      <= 1'b1;
            last_area_q <= area;
            last_wr_q   <= wr;
        end
    end

    // Collision possible on area change or write after read.
    always_comb begin
        hazard = seen_q && ((area != last_area_q) || (wr && !last_wr_q));
    end
endmodule

// File: rtl/gap_timer.sv
// Down-counter of idle cycles still owed. It loads on every accepted
// access and stops at zero.
module gap_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);
    // Load, then count down once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_n) cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    // Busy while idle cycles remain.
    always_comb busy = (cnt != '0);
endmodule

// File: rtl/turnaround_gap_ctrl.sv
// Top: inserts idle cycles between external accesses when a bus driver
// collision is possible. Assumes the requester holds area, direction and
// DMA flag stable while req_valid is high and ready is low.
module turnaround_gap_ctrl
    import gap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic              req_dma
);
    cfg_t   cfg_q;
    logic   hazard;
    logic   busy;
    logic   accept;
    slot_t  cur_slot;
    field_t load_val;
    field_t gap_cnt;

    gap_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    gap_history u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .warm_n (warm_rst_n),
        .accept (accept),
        .area   (req_area),
        .wr     (req_write),
        .hazard (hazard)
    );

    gap_timer #(.CNT_W(FIELD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_n   (warm_rst_n),
        .load     (accept),
        .load_val (load_val),
        .cnt      (gap_cnt),
        .busy     (busy)
    );

    // Slot of the presented access: DMA uses the shared top slot.
    always_comb begin
        cur_slot = req_dma ? slot_t'(DMA_SLOT) : req_area;
        load_val = pick_field(cfg_q, cur_slot);
    end

    // Handshake: stall only a colliding access while a gap is owed.
    always_comb begin
        req_ready = !(hazard && busy);
        accept    = req_valid && req_ready;
    end

    assign cfg_rdata = cfg_q;
endmodule

// File: rtl/turnaround_gap_sva.sv
// Property checker for turnaround_gap_ctrl, bound to every instance.
module turnaround_gap_sva
    import gap_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             warm_rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             req_ready,
    input logic             accept,
    input logic             busy,
    input logic [FIELD_W-1:0] gap_cnt
);
    assert_por_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_rdata == 32'h7777_7777);

    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & 32'h8888_8888) == 32'h0);

    assert_warm_keeps_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst_n && !cfg_we) |=> $stable(cfg_rdata));

    assert_warm_frees_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> req_ready);

    assert_stall_needs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> busy);

    assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept && warm_rst_n) |=> gap_cnt == $past(gap_cnt) - 3'd1);
endmodule

bind turnaround_gap_ctrl turnaround_gap_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .req_ready  (req_ready),
    .accept     (accept),
    .busy       (busy),
    .gap_cnt    (gap_cnt)
);

// File: tb/turnaround_gap_ctrl_test.sv
`timescale 1ns/1ps
module turnaround_gap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n, warm_rst_n, cfg_we, req_valid, req_write, req_dma;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [2:0]  req_area;
    logic        req_ready;

    always #2 clk = ~clk;

    turnaround_gap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
        .req_write(req_write), .req_dma(req_dma)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc++;

    // Reference model state
    logic [31:0] m_cfg;
    bit          m_seen;
    int          m_area, m_field, m_acc;
    bit          m_wr;

    function automatic int exp_stall(int area, bit wr, int elapsed);
        int r;
        if (!m_seen) return 0;
        if (area != m_area || (wr && !m_wr)) begin
            r = m_field - elapsed;
            return (r > 0) ? r : 0;
        end
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_cfg(string tag, logic [31:0] exp);
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic wr_cfg(logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg = d & 32'h7777_7777;
    endtask

    task automatic warm_pulse();
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        m_seen = 0;
    endtask

    task automatic por_pulse();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cfg = 32'h7777_7777;
        m_seen = 0;
    endtask

    task automatic do_req(int area, bit wr, bit dma, int gap, string tag);
        int exp, stalls, slot;
        repeat (gap) @(negedge clk);
        exp = exp_stall(area, wr, cyc - m_acc);
        req_valid = 1'b1; req_area = 3'(area); req_write = wr; req_dma = dma;
        #0.5;
        stalls = 0;
        while (!req_ready && stalls < 20) begin
            stalls++;
            @(negedge clk);
            #0.5;
        end
        @(negedge clk);
        req_valid = 1'b0;
        m_acc = cyc;
        m_seen = 1; m_area = area; m_wr = wr;
        slot = dma ? 7 : area;
        m_field = int'((m_cfg >> (4 * slot)) & 32'h7);
        check(tag, stalls, exp);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; warm_rst_n = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_area = '0; req_write = 1'b0; req_dma = 1'b0;
        m_cfg = 32'h7777_7777; m_seen = 0; m_acc = 0; m_area = 0; m_wr = 0; m_field = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cfg("R1 power-on value", 32'h7777_7777);

        // R2: spare bits stay zero
        wr_cfg(32'hFFFF_FFFF); check_cfg("R2 all ones", 32'h7777_7777);
        wr_cfg(32'h8888_8888); check_cfg("R2 spare only", 32'h0000_0000);
        wr_cfg(32'h1234_5670); check_cfg("R2 pattern", 32'h1234_5670);

        // slot k holds k, slot 7 holds 7
        wr_cfg(32'h7654_3210);
        do_req(0, 0, 0, 0, "R11 first access");
        do_req(3, 0, 0, 0, "R9 zero count");
        do_req(5, 0, 0, 0, "R5 area change");
        do_req(5, 0, 0, 0, "R7 read after read");
        do_req(5, 1, 0, 0, "R6 write after read");
        do_req(5, 1, 0, 0, "R7 write after write");
        do_req(5, 0, 0, 0, "R7 read after write");
        do_req(2, 0, 1, 0, "R5 into dma");
        do_req(4, 0, 0, 0, "R8 after dma");
        do_req(6, 0, 0, 3, "R9 elapsed idle");
        do_req(7, 0, 0, 0, "R3 into area 7");
        do_req(0, 0, 0, 0, "R3 area 7 slot");
        do_req(1, 0, 0, 0, "R3 zero slot");
        do_req(2, 0, 0, 0, "R3 slot 1");
        // R10: raise slot 2 while its gap of 2 runs; expect 2-1
        wr_cfg(32'h7654_3710);
        do_req(3, 0, 0, 0, "R10 mid-gap write");
        n_chk++;
        if (m_seen && m_field != 3) begin
            n_bad++; $display("FAIL R10 model: actual %0d expected 3", m_field);
        end

        // R4: warm reset keeps configuration, frees the bus
        wr_cfg(32'h1234_5670);
        do_req(3, 0, 0, 0, "R4 setup");
        warm_pulse();
        check_cfg("R4 config kept", 32'h1234_5670);
        do_req(6, 1, 0, 0, "R4 history cleared");
        do_req(1, 0, 0, 0, "R4 setup long gap");
        warm_pulse();
        do_req(2, 0, 0, 0, "R4 gap cleared");

        // R1 again after a later power-on reset
        por_pulse();
        @(negedge clk);
        check_cfg("R1 second power-on", 32'h7777_7777);
        do_req(4, 1, 0, 0, "R11 after power-on");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom % 64);
            if (sel < 8) begin
                logic [31:0] d;
                d = $urandom;
                wr_cfg(d);
                check_cfg("R2 random write", d & 32'h7777_7777);
            end else if (sel == 9) begin
                warm_pulse();
            end
            do_req(int'($urandom % 8), 1'($urandom % 2), ($urandom % 6) == 0,
                   int'($urandom % 4), "R5 R6 R7 R8 R9 random");
        end
        finish_up();
    end
endmodule